// File: doc/BRIEF.md
# Variable Pulse Width Frame Transmitter

This block turns a short frame of bytes into a waveform on a single-wire bus. The waveform uses variable pulse width coding. The bus is either active (driven) or passive (released), and its level flips at every symbol boundary. Each bit has exactly one transition. Its value is carried by how long the current level is held, and whether that hold is short or long depends on the level the bit happens to fall on.

A host starts a frame by pulsing a start strobe together with a data-byte count. It then supplies the bytes through a valid/ready handshake, and a one-byte holding slot prefetches the next byte while the current one is being serialized. The block sends a long active start symbol, then the data bytes, then a CRC byte it computes itself. It finishes with a passive end-of-data and end-of-frame gap, and marks the end of that gap with a one-cycle done pulse.

All durations are counted in microseconds. A prescaler derived from the system clock (`CLK_PER_US` cycles per microsecond) sets the length of one microsecond.

Top module: `vpw_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `bus_active_o` is 0 (passive), `busy_o` is 0 and `byte_ready_o` is 0.
- R2: An accepted start drives the bus active from the next cycle for exactly `SOF_US` microseconds (200).
- R3: A data bit lasts `LONG_US` (128) or `SHORT_US` (64) microseconds. A 1 on a passive level is long and a 1 on an active level is short. A 0 on a passive level is short and a 0 on an active level is long. The level alternates every bit, and the first bit of every byte is passive.
- R4: Each byte is sent as eight bits, bit 7 first.
- R5: After the last data byte, one CRC byte is sent with the same coding. The CRC uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), is preset to 0xFF, runs over the data bytes only with each byte taken bit 7 first, and is inverted before it is sent.
- R6: After the last CRC bit, the bus stays passive for `EOF_US` (280) microseconds. This gap covers both the 200 µs end-of-data and the end-of-frame. `done_o` is then high for exactly one cycle, in the same cycle `busy_o` returns to 0.
- R7: A start with a count from 1 to `MAX_FRAME`-1 (11) is accepted. A start with a count of 0, or with any count above 11, raises `reject_o` for one cycle in the next cycle and sends nothing.
- R8: A start strobe during a frame is ignored: the frame waveform is unchanged and `reject_o` stays 0.
- R9: `byte_ready_o` is high only during a frame, while the holding slot is empty and some of the counted bytes are still untaken. Exactly the counted number of bytes is taken per frame.
- R10: Every symbol duration equals its microsecond count times `CLK_PER_US` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| len_i | input | LEN_W (4) | Number of data bytes in the frame |
| byte_i | input | 8 | Data byte offered to the block |
| byte_valid_i | input | 1 | `byte_i` holds a valid byte |
| byte_ready_o | output | 1 | Block takes the byte this cycle if valid |
| bus_active_o | output | 1 | 1 = drive bus active, 0 = release (passive) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of the frame |
| reject_o | output | 1 | One-cycle pulse for a start with an illegal count |

## Verification
The bench builds the block with `CLK_PER_US = 2`. This keeps a full 11-byte frame to about twenty thousand cycles, which leaves room for many frames in one run. It also keeps the prescaler doing real division, so a wrong tick spacing changes every measured run length. The bench decodes each frame into the run lengths between bus transitions and compares them with a list built from the bytes and its own bitwise CRC. That list covers the start symbol, both bit widths on both levels, and the final passive gap. Directed frames cover the one-byte and maximum lengths, all-zero and all-one bytes, and a start pulse during a frame. Random frames from a fixed seed cover everything else.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOF  = 2'd1,
        ST_BITS = 2'd2,
        ST_TAIL = 2'd3
    } vpw_state_e;

    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_INIT = 8'hFF;

    // Advance the CRC register over one byte, bit 7 first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        c = crc;
        for (int i = 7; i >= 0; i--) begin
            if (c[7] ^ data[i]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else                c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/vpw_tick.sv
module vpw_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } tick_reg_t;

    tick_reg_t r_d, r_q;

    assign tick_o = run_i && (r_q.pre == LAST);

    always_comb begin
        r_d = r_q;
        if (restart_i || !run_i) r_d.pre = '0;
        else if (tick_o)         r_d.pre = '0;
        else                     r_d.pre = r_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (CLK_PER_US > 1) begin : g_div
            // R10: with a real divider, ticks are never back to back
            p_tick_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/vpw_byte_slot.sv
module vpw_byte_slot #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    input  logic             valid_i,
    output logic             ready_o,
    output logic             full_o,
    output logic [7:0]       data_o
);
    typedef struct packed {
        logic [LEN_W-1:0] left;
        logic             full;
        logic [7:0]       data;
    } slot_reg_t;

    slot_reg_t s_d, s_q;

    assign ready_o = !s_q.full && (s_q.left != '0);
    assign full_o  = s_q.full;
    assign data_o  = s_q.data;

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.left = len_i;
            s_d.full = 1'b0;
        end else begin
            if (take_i) s_d.full = 1'b0;
            if (valid_i && ready_o) begin
                s_d.full = 1'b1;
                s_d.data = byte_i;
                s_d.left = s_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: the serializer only consumes a byte that is present
    p_take_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> s_q.full);
    // R9: an accepted byte fills the slot
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o && !load_i) |=> s_q.full);

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
    import vpw_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int MAX_FRAME  = 12,
    parameter int SHORT_US   = 64,
    parameter int LONG_US    = 128,
    parameter int SOF_US     = 200,
    parameter int EOF_US     = 280,
    parameter int LEN_W      = $clog2(MAX_FRAME)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [7:0]       byte_i,
    input  logic             byte_valid_i,
    output logic             byte_ready_o,
    output logic             bus_active_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             reject_o
);
    localparam int MAX_DATA = MAX_FRAME - 1;
    localparam int MAX_US   = (EOF_US > SOF_US) ? EOF_US : SOF_US;
    localparam int US_W     = $clog2(MAX_US + 1);

    localparam logic [US_W-1:0] SHORT_M1 = US_W'(SHORT_US - 1);
    localparam logic [US_W-1:0] LONG_M1  = US_W'(LONG_US - 1);
    localparam logic [US_W-1:0] SOF_M1   = US_W'(SOF_US - 1);
    localparam logic [US_W-1:0] EOF_M1   = US_W'(EOF_US - 1);

    typedef struct packed {
        vpw_state_e       st;
        logic             lvl;
        logic [US_W-1:0]  us;
        logic [7:0]       shift;
        logic [2:0]       bit_idx;
        logic [LEN_W-1:0] data_left;
        logic             is_crc;
        logic [7:0]       crc;
        logic             done;
        logic             reject;
    } tx_reg_t;

    tx_reg_t r_d, r_q;

    logic            tick;
    logic            restart;
    logic            take;
    logic            slot_full;
    logic [7:0]      slot_data;
    logic [US_W-1:0] dur_m1;
    logic            sym_end;
    logic            len_ok;

    vpw_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (r_q.st != ST_IDLE),
        .restart_i (restart),
        .tick_o    (tick)
    );

    vpw_byte_slot #(.LEN_W(LEN_W)) i_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (restart),
        .len_i   (len_i),
        .take_i  (take),
        .byte_i  (byte_i),
        .valid_i (byte_valid_i),
        .ready_o (byte_ready_o),
        .full_o  (slot_full),
        .data_o  (slot_data)
    );

    assign len_ok = (len_i != '0) && (32'(len_i) <= MAX_DATA);

    // Duration of the symbol now on the line, minus one microsecond.
    always_comb begin
        unique case (r_q.st)
            ST_SOF:  dur_m1 = SOF_M1;
            ST_TAIL: dur_m1 = EOF_M1;
            ST_BITS: dur_m1 = (r_q.lvl ^ r_q.shift[7]) ? LONG_M1 : SHORT_M1;
            default: dur_m1 = SHORT_M1;
        endcase
    end

    assign sym_end = tick && (r_q.us == dur_m1);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        r_d.reject = 1'b0;
        restart    = 1'b0;
        take       = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (len_ok) begin
                        restart       = 1'b1;
                        r_d.st        = ST_SOF;
                        r_d.lvl       = 1'b1;
                        r_d.us        = '0;
                        r_d.crc       = CRC_INIT;
                        r_d.data_left = len_i - 1'b1;
                        r_d.is_crc    = 1'b0;
                    end else begin
                        r_d.reject = 1'b1;
                    end
                end
            end
            ST_SOF: begin
                if (sym_end) begin
                    if (slot_full) begin
                        take        = 1'b1;
                        r_d.shift   = slot_data;
                        r_d.crc     = crc8_byte(r_q.crc, slot_data);
                        r_d.st      = ST_BITS;
                        r_d.lvl     = 1'b0;
                        r_d.us      = '0;
                        r_d.bit_idx = '0;
                    end
                end else if (tick) begin
                    r_d.us = r_q.us + 1'b1;
                end
            end
            ST_BITS: begin
                if (sym_end) begin
                    if (r_q.bit_idx != 3'd7) begin
                        r_d.shift   = {r_q.shift[6:0], 1'b0};
                        r_d.bit_idx = r_q.bit_idx + 1'b1;
                        r_d.lvl     = !r_q.lvl;
                        r_d.us      = '0;
                    end else if (r_q.is_crc) begin
                        r_d.st  = ST_TAIL;
                        r_d.lvl = 1'b0;
                        r_d.us  = '0;
                    end else if (r_q.data_left == '0) begin
                        r_d.shift   = ~r_q.crc;
                        r_d.is_crc  = 1'b1;
                        r_d.bit_idx = '0;
                        r_d.lvl     = 1'b0;
                        r_d.us      = '0;
                    end else if (slot_full) begin
                        take          = 1'b1;
                        r_d.shift     = slot_data;
                        r_d.crc       = crc8_byte(r_q.crc, slot_data);
                        r_d.data_left = r_q.data_left - 1'b1;
                        r_d.bit_idx   = '0;
                        r_d.lvl       = 1'b0;
                        r_d.us        = '0;
                    end
                end else if (tick) begin
                    r_d.us = r_q.us + 1'b1;
                end
            end
            ST_TAIL: begin
                if (sym_end) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.us   = '0;
                end else if (tick) begin
                    r_d.us = r_q.us + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bus_active_o = r_q.lvl;
    assign busy_o       = (r_q.st != ST_IDLE);
    assign done_o       = r_q.done;
    assign reject_o     = r_q.reject;

    // R1: no frame means a released line
    p_idle_passive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_active_o && !byte_ready_o));
    // R2: the start symbol is held active throughout
    p_sof_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SOF) |-> bus_active_o);
    // R3: every byte opens on the passive level
    p_first_passive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BITS && r_q.bit_idx == 3'd0) |-> !bus_active_o);
    // R3: the microsecond count never passes the current symbol length
    p_us_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (r_q.us <= dur_m1));
    // R3: within a byte the level flips at each bit boundary
    p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BITS && sym_end && r_q.bit_idx != 3'd7) |=> (bus_active_o != $past(bus_active_o)));
    // R6: done is a single-cycle pulse on an idle block
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !bus_active_o)) ;
    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: a rejection never starts a frame
    p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> !busy_o);
    // R8: a start pulse during a frame neither rejects nor restarts
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && r_q.st != ST_TAIL) |=> (busy_o && !reject_o));

endmodule

// File: tb/test_vpw_tx.sv
module test_vpw_tx;
    localparam int CPU   = 2;
    localparam int MAXF  = 12;
    localparam int LW    = 4;
    localparam int SHORT = 64;
    localparam int LONG  = 128;
    localparam int SOFU  = 200;
    localparam int EOFU  = 280;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic [7:0]    byte_i = '0;
    logic          byte_valid_i = 1'b0;
    logic          byte_ready_o, bus_active_o, busy_o, done_o, reject_o;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] frm [MAXF];

    always #10 clk = ~clk;

    vpw_tx #(.CLK_PER_US(CPU), .MAX_FRAME(MAXF)) i_vpw_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .byte_i(byte_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
        .bus_active_o(bus_active_o), .busy_o(busy_o), .done_o(done_o), .reject_o(reject_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_ref(input int n);
        logic [7:0] c = 8'hFF;
        for (int b = 0; b < n; b++)
            for (int i = 7; i >= 0; i--) begin
                logic fb = c[7] ^ frm[b][i];
                c = {c[6:0], 1'b0};
                if (fb) c = c ^ 8'h1D;
            end
        return ~c;
    endfunction

    function automatic int bit_cycles(input bit active, input bit v);
        if (!active) return (v ? LONG : SHORT) * CPU;
        return (v ? SHORT : LONG) * CPU;
    endfunction

    task automatic reject_case(input int l);
        @(negedge clk); start_i = 1'b1; len_i = LW'(l);
        @(negedge clk); start_i = 1'b0;
        chk(reject_o == 1'b1, "R7", "reject pulse", int'(reject_o), 1);
        chk(busy_o == 1'b0, "R7", "no frame after reject", int'(busy_o), 0);
        chk(byte_ready_o == 1'b0, "R9", "ready idle", int'(byte_ready_o), 0);
        @(negedge clk);
        chk(reject_o == 1'b0, "R7", "reject single cycle", int'(reject_o), 0);
        chk(bus_active_o == 1'b0, "R1", "line passive", int'(bus_active_o), 0);
    endtask

    task automatic run_frame(input int n, input bit poke);
        int exp_q[$];
        int crc_at, k, run, idx, rejected, cyc;
        bit lvl_prev, pend, ended;
        logic [7:0] all [MAXF];
        for (int b = 0; b < n; b++) all[b] = frm[b];
        all[n] = crc_ref(n);
        exp_q.push_back(SOFU * CPU);
        crc_at = 0;
        for (int b = 0; b <= n; b++) begin
            if (b == n) crc_at = exp_q.size();
            for (int j = 0; j < 8; j++)
                exp_q.push_back(bit_cycles(j[0], all[b][7-j]));
        end
        exp_q.push_back(EOFU * CPU);

        @(negedge clk); start_i = 1'b1; len_i = LW'(n);
        @(negedge clk); start_i = 1'b0;
        chk(busy_o == 1'b1, "R7", "legal count accepted", int'(busy_o), 1);
        k = 0; run = 0; idx = 0; rejected = 0; cyc = 0;
        lvl_prev = 1'b1; pend = 1'b0; ended = 1'b0;
        while (cyc < 40000 && !ended) begin
            if (pend) idx++;
            byte_valid_i = (idx < n);
            byte_i = (idx < n) ? frm[idx] : 8'h00;
            pend = byte_valid_i && byte_ready_o;
            if (reject_o) rejected++;
            if (poke && cyc == 300)      begin start_i = 1'b1; len_i = LW'(3); end
            else if (poke && cyc == 301) start_i = 1'b0;
            if (done_o) begin
                chk(run == exp_q[k] && k == exp_q.size() - 1, "R6", "final passive gap",
                    run, exp_q[exp_q.size() - 1]);
                chk(busy_o == 1'b0, "R6", "busy clears with done", int'(busy_o), 0);
                ended = 1'b1;
            end else begin
                if (bus_active_o == lvl_prev) run++;
                else begin
                    if (k == 0)
                        chk(run == exp_q[k], "R2/R10", "start symbol", run, exp_q[k]);
                    else if (k >= crc_at && k < exp_q.size() - 1)
                        chk(run == exp_q[k], "R5", "crc bit", run, exp_q[k]);
                    else if (k < exp_q.size())
                        chk(run == exp_q[k], "R3 R4", "data bit", run, exp_q[k]);
                    else
                        chk(1'b0, "R3", "extra transition", k, exp_q.size());
                    k++;
                    lvl_prev = bus_active_o;
                    run = 1;
                end
                cyc++;
                @(negedge clk);
            end
        end
        byte_valid_i = 1'b0;
        chk(ended, "R6", "frame ended", int'(ended), 1);
        chk(idx == n, "R9", "bytes taken", idx, n);
        if (poke) chk(rejected == 0, "R8", "start ignored while busy", rejected, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R6", "done single cycle", int'(done_o), 0);
        chk(byte_ready_o == 1'b0 && bus_active_o == 1'b0, "R1", "idle after frame",
            int'({byte_ready_o, bus_active_o}), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; vectors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_active_o == 1'b0, "R1", "reset line", int'(bus_active_o), 0);
        chk(busy_o == 1'b0, "R1", "reset busy", int'(busy_o), 0);
        chk(byte_ready_o == 1'b0, "R1", "reset ready", int'(byte_ready_o), 0);
        chk(done_o == 1'b0 && reject_o == 1'b0, "R1", "reset pulses", int'({done_o, reject_o}), 0);

        reject_case(0);
        reject_case(12);
        reject_case(15);

        frm[0] = 8'h00;                run_frame(1, 1'b0);
        frm[0] = 8'hFF;                run_frame(1, 1'b0);
        for (int b = 0; b < 11; b++) frm[b] = (b % 2 == 0) ? 8'hA5 : 8'h3C;
        run_frame(11, 1'b0);
        frm[0] = 8'h81; frm[1] = 8'h7E; run_frame(2, 1'b1);

        for (int f = 0; f < 6; f++) begin
            int n = 1 + int'($urandom % 4);
            for (int b = 0; b < n; b++) frm[b] = 8'($urandom);
            run_frame(n, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule